// File: doc/BRIEF.md
# Packed Variable-Length Instruction Decoder

This block turns a byte stream of tightly packed instructions into one decoded record per instruction. The first byte of each instruction is its opcode. The opcode picks an operand format, and the format fixes how many register bytes and immediate bytes follow. Operands sit directly after the opcode with no alignment. The first byte after the last operand is the next opcode.

The decoder gathers the register bytes into numbered slots. It assembles the little-endian 64-bit immediate. It then presents a record holding the opcode, the four register slots, the immediate, the total length in bytes and a trap flag. A downstream program counter can advance by the reported length.

Both edges of the block are valid/ready streams, and a byte or record moves only on a cycle where valid and ready are both high. While a record is waiting for `out_ready`, the decoder holds it unchanged and keeps `in_ready` low. Back-pressure on the output therefore stops consumption of input bytes. An illegal opcode or an out-of-range register byte produces a single trap record. After that the decoder refuses all input until a synchronous reset.

Top module: `pkd_insn_decoder`

## Requirements
- R1: In the cycle after a synchronous reset (`rst` high at a clock edge), `in_ready` is 1 and `out_valid` is 0.
- R2: The operand byte count depends on the opcode:
  - 0 and 45: 0 bytes.
  - 1–11, 46 and 47: 3 register bytes.
  - 12 and 48: 4 register bytes.
  - 13, 14 and 28: 2 register bytes.
  - 29 and 38: 1 register byte followed by 8 immediate bytes.
  - 18–27, 30–37, 39–44, 49 and 50: 2 register bytes followed by 8 immediate bytes.

  For a legal record, `out_len` is this count plus one.
- R3: Register bytes fill slots in arrival order. Slot k is `out_regs[8k+7:8k]`. Slots that the format does not use read 0.
- R4: The first immediate byte received is `out_imm[7:0]` and the eighth is `out_imm[63:56]`. A format without an immediate gives `out_imm` = 0.
- R5: Instructions are back to back. The byte after an instruction's last operand is decoded as the next opcode, and a legal stream is consumed exactly.
- R6: Opcodes 15, 16, 17 and 51–255 produce a record with `out_trap`=1, `out_opcode` equal to the offending byte and `out_len`=1. No operand bytes are consumed for it.
- R7: A register byte above 59 produces a record with `out_trap`=1 and `out_opcode` equal to the instruction's opcode. This record is issued after all of that instruction's operand bytes are consumed, and its `out_len` is the full length. A register byte of 59 is legal.
- R8: Once a trap record has been accepted, `in_ready` and `out_valid` stay 0 until reset.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field stays constant. `in_ready` is 0 whenever `out_valid` is 1.
- R10: Cycles with `in_valid` low do not alter the decoded records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_opcode | output | 8 | Opcode byte |
| out_regs | output | 32 | Four register slots, slot k at bits 8k+7:8k |
| out_imm | output | 64 | Assembled immediate |
| out_len | output | 4 | Instruction length in bytes, opcode included |
| out_trap | output | 1 | Record reports an illegal opcode or register |

## Verification
A record becomes valid in the cycle after the edge that accepts its last byte. For a format without operands, that byte is the opcode itself. After the edge that accepts the record, `in_ready` rises again in the next cycle.

The bench drives inputs on the falling edge and lets the combinational ready and valid settle. It then judges a transfer from the values that will hold at the next rising edge, so every comparison sees exactly the record presented in that cycle. On stalled cycles the bench compares the fields with those of the previous cycle. After a trap it watches for many cycles that nothing moves.

// File: rtl/pkd_dec_pkg.sv
package pkd_dec_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_RF    = 4;
  localparam int IMM_BYTES = 8;
  localparam int POS_W     = 4;
  localparam int LEN_W     = 4;

  typedef enum logic [2:0] {
    FMT_N, FMT_RR, FMT_RRR, FMT_RRRR, FMT_RI, FMT_RRI, FMT_I, FMT_BAD
  } fmt_e;

  typedef enum logic [1:0] {
    S_OP, S_ARG, S_OUT, S_HALT
  } dec_st_e;
endpackage

// File: rtl/pkd_fmt_lut.sv
module pkd_fmt_lut
  import pkd_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output logic [POS_W-1:0]  n_regs,
  output logic [POS_W-1:0]  n_imm,
  output logic              legal
);
  fmt_e fmt;

  always_comb begin
    if (opcode == 8'd0 || opcode == 8'd45)
      fmt = FMT_N;
    else if (opcode inside {[8'd1:8'd11], 8'd46, 8'd47})
      fmt = FMT_RRR;
    else if (opcode == 8'd12 || opcode == 8'd48)
      fmt = FMT_RRRR;
    else if (opcode inside {8'd13, 8'd14, 8'd28})
      fmt = FMT_RR;
    else if (opcode inside {[8'd18:8'd27], [8'd30:8'd37], [8'd39:8'd44], 8'd49, 8'd50})
      fmt = FMT_RRI;
    else if (opcode == 8'd29 || opcode == 8'd38)
      fmt = FMT_RI;
    else
      fmt = FMT_BAD;
  end

  always_comb begin
    legal  = 1'b1;
    n_regs = '0;
    n_imm  = '0;
    case (fmt)
      FMT_N:    ;
      FMT_RR:   n_regs = POS_W'(2);
      FMT_RRR:  n_regs = POS_W'(3);
      FMT_RRRR: n_regs = POS_W'(4);
      FMT_RI:   begin n_regs = POS_W'(1); n_imm = POS_W'(IMM_BYTES); end
      FMT_RRI:  begin n_regs = POS_W'(2); n_imm = POS_W'(IMM_BYTES); end
      FMT_I:    n_imm = POS_W'(IMM_BYTES);
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/pkd_operand_asm.sv
module pkd_operand_asm
  import pkd_dec_pkg::*;
#(
  parameter int SLOTS   = NUM_RF,
  parameter int IMM_B   = IMM_BYTES,
  parameter int REG_MAX = 59
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    load,
  input  logic [POS_W-1:0]        pos,
  input  logic [POS_W-1:0]        n_regs,
  input  logic [BYTE_W-1:0]       data,
  output logic [SLOTS*BYTE_W-1:0] regs,
  output logic [IMM_B*BYTE_W-1:0] imm,
  output logic                    bad_reg
);
  logic             is_reg;
  logic [POS_W-1:0] imm_idx;

  assign is_reg  = pos < n_regs;
  assign imm_idx = pos - n_regs;

  // one byte-wide register per register slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || clear)
        slot_q <= '0;
      else if (load && is_reg && pos == POS_W'(g))
        slot_q <= data;
    end
    assign regs[g*BYTE_W +: BYTE_W] = slot_q;
  end

  // immediate bytes, least significant first
  for (genvar b = 0; b < IMM_B; b++) begin : g_imm
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clear)
        byte_q <= '0;
      else if (load && !is_reg && imm_idx == POS_W'(b))
        byte_q <= data;
    end
    assign imm[b*BYTE_W +: BYTE_W] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      bad_reg <= 1'b0;
    else if (load && is_reg && data > BYTE_W'(REG_MAX))
      bad_reg <= 1'b1;
  end
endmodule

// File: rtl/pkd_insn_decoder.sv
module pkd_insn_decoder
  import pkd_dec_pkg::*;
#(
  parameter int REG_MAX = 59
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [BYTE_W-1:0]          in_byte,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [BYTE_W-1:0]          out_opcode,
  output logic [NUM_RF*BYTE_W-1:0]   out_regs,
  output logic [IMM_BYTES*BYTE_W-1:0] out_imm,
  output logic [LEN_W-1:0]           out_len,
  output logic                       out_trap
);
  dec_st_e           st_q;
  logic [BYTE_W-1:0] opc_q;
  logic [POS_W-1:0]  nreg_q, narg_q, pos_q;
  logic              bad_op_q;

  logic [POS_W-1:0]  lut_nregs, lut_nimm, lut_nargs;
  logic              lut_ok, take, bad_reg;

  pkd_fmt_lut u_lut (
    .opcode (in_byte),
    .n_regs (lut_nregs),
    .n_imm  (lut_nimm),
    .legal  (lut_ok)
  );

  assign lut_nargs = lut_nregs + lut_nimm;
  assign in_ready  = (st_q == S_OP) || (st_q == S_ARG);
  assign take      = in_valid && in_ready;

  pkd_operand_asm #(
    .SLOTS   (NUM_RF),
    .IMM_B   (IMM_BYTES),
    .REG_MAX (REG_MAX)
  ) u_asm (
    .clk     (clk),
    .rst     (rst),
    .clear   (take && st_q == S_OP),
    .load    (take && st_q == S_ARG),
    .pos     (pos_q),
    .n_regs  (nreg_q),
    .data    (in_byte),
    .regs    (out_regs),
    .imm     (out_imm),
    .bad_reg (bad_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_OP;
      opc_q    <= '0;
      nreg_q   <= '0;
      narg_q   <= '0;
      pos_q    <= '0;
      bad_op_q <= 1'b0;
    end else begin
      case (st_q)
        S_OP: if (take) begin
          opc_q    <= in_byte;
          nreg_q   <= lut_nregs;
          narg_q   <= lut_nargs;
          pos_q    <= '0;
          bad_op_q <= !lut_ok;
          st_q     <= (!lut_ok || lut_nargs == '0) ? S_OUT : S_ARG;
        end
        S_ARG: if (take) begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == narg_q - 1'b1)
            st_q <= S_OUT;
        end
        S_OUT: if (out_ready)
          st_q <= out_trap ? S_HALT : S_OP;
        default: st_q <= S_HALT;
      endcase
    end
  end

  assign out_valid  = (st_q == S_OUT);
  assign out_opcode = opc_q;
  assign out_trap   = bad_op_q || bad_reg;
  assign out_len    = LEN_W'(narg_q) + 1'b1;
endmodule

// File: rtl/pkd_insn_decoder_chk.sv
module pkd_insn_decoder_chk
  import pkd_dec_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [BYTE_W-1:0]           in_byte,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [BYTE_W-1:0]           out_opcode,
  input logic [NUM_RF*BYTE_W-1:0]    out_regs,
  input logic [IMM_BYTES*BYTE_W-1:0] out_imm,
  input logic [LEN_W-1:0]            out_len,
  input logic                        out_trap
);
  logic halted;
  logic op_illegal;

  assign op_illegal = (out_opcode inside {[8'd15:8'd17]}) || (out_opcode > 8'd50);

  always_ff @(posedge clk) begin
    if (rst)
      halted <= 1'b0;
    else if (out_valid && out_ready && out_trap)
      halted <= 1'b1;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_regs)
      && $stable(out_imm) && $stable(out_len) && $stable(out_trap));

  // R9
  no_take_while_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !in_ready && !out_valid);

  // R2
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_trap |-> out_len inside {4'd1, 4'd3, 4'd4, 4'd5, 4'd10, 4'd11});

  // R6
  bad_op_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && op_illegal |-> out_trap && out_len == 4'd1);

  // R5
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_trap |=> in_ready && !out_valid);

  logic unused_ok;
  assign unused_ok = in_valid ^ (^in_byte);
endmodule

bind pkd_insn_decoder pkd_insn_decoder_chk u_chk (.*);

// File: tb/pkd_insn_decoder_bench.sv
module pkd_insn_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_opcode;
  logic [31:0] out_regs;
  logic [63:0] out_imm;
  logic [3:0]  out_len;
  logic        out_trap;

  always #10 clk = ~clk;

  pkd_insn_decoder u_pkd_insn_decoder (.*);

  typedef struct {
    logic [7:0]  op;
    logic [31:0] regs;
    logic [63:0] imm;
    logic [3:0]  len;
    logic        trap;
  } exp_t;

  int          checks = 0;
  int          errors = 0;
  logic [7:0]  stream[$];
  exp_t        exp_q[$];

  function automatic bit f_legal(input logic [7:0] op);
    return !((op >= 8'd15 && op <= 8'd17) || op > 8'd50);
  endfunction

  function automatic int f_nregs(input logic [7:0] op);
    if (op inside {[8'd1:8'd11], 8'd46, 8'd47}) return 3;
    if (op == 8'd12 || op == 8'd48) return 4;
    if (op inside {8'd13, 8'd14, 8'd28, [8'd18:8'd27], [8'd30:8'd37], [8'd39:8'd44], 8'd49, 8'd50}) return 2;
    if (op == 8'd29 || op == 8'd38) return 1;
    return 0;
  endfunction

  function automatic int f_nimm(input logic [7:0] op);
    if (op inside {8'd29, 8'd38, [8'd18:8'd27], [8'd30:8'd37], [8'd39:8'd44], 8'd49, 8'd50}) return 8;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_insn(input logic [7:0] op, input logic [31:0] regs, input logic [63:0] imm);
    exp_t e;
    int   nr, ni;
    nr = f_nregs(op);
    ni = f_nimm(op);
    e.op = op; e.regs = '0; e.imm = '0; e.trap = !f_legal(op);
    e.len = 4'(1 + nr + ni);
    stream.push_back(op);
    if (f_legal(op)) begin
      for (int k = 0; k < nr; k++) begin
        stream.push_back(regs[8*k +: 8]);
        e.regs[8*k +: 8] = regs[8*k +: 8];
        if (regs[8*k +: 8] > 8'd59) e.trap = 1'b1;
      end
      for (int b = 0; b < ni; b++) stream.push_back(imm[8*b +: 8]);
      if (ni > 0) e.imm = imm;
    end
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] rand_regs();
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'($urandom % 60);
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    stream.delete(); exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic run(input bit halt_end);
    int   idx = 0;
    int   cyc = 0;
    bit   hold = 1'b0;
    exp_t e;
    logic [7:0]  h_op;
    logic [31:0] h_regs;
    logic [63:0] h_imm;
    logic [3:0]  h_len;
    logic        h_trap;
    while (exp_q.size() > 0 && cyc < 20000) begin
      @(negedge clk);
      if (hold) begin // R9 stall stability
        chk("R9", "held valid", 64'(out_valid), 64'd1);
        chk("R9", "held fields", {h_op, h_regs, h_len, h_trap} ^ 64'(h_imm),
            {out_opcode, out_regs, out_len, out_trap} ^ 64'(out_imm));
      end
      // R10: random gaps on the input
      in_valid  = (idx < stream.size()) && ($urandom % 4 != 0);
      in_byte   = in_valid ? stream[idx] : 8'($urandom);
      out_ready = ($urandom % 10) < 7;
      #1;
      if (out_valid) chk("R9", "in_ready low while out_valid", 64'(in_ready), 64'd0);
      if (in_valid && in_ready) idx++;
      hold = out_valid && !out_ready;
      h_op = out_opcode; h_regs = out_regs; h_imm = out_imm; h_len = out_len; h_trap = out_trap;
      if (out_valid && out_ready) begin
        e = exp_q.pop_front();
        if (e.trap) begin
          chk(f_legal(e.op) ? "R7" : "R6", "trap flag", 64'(out_trap), 64'd1);
          chk(f_legal(e.op) ? "R7" : "R6", "trap opcode", 64'(out_opcode), 64'(e.op));
          chk(f_legal(e.op) ? "R7" : "R6", "trap length", 64'(out_len), 64'(e.len));
        end else begin
          chk("R2", "length", 64'(out_len), 64'(e.len));
          chk("R5", "opcode", 64'(out_opcode), 64'(e.op));
          chk("R3", "regs", 64'(out_regs), 64'(e.regs));
          chk("R4", "imm", out_imm, e.imm);
          chk("R7", "no trap", 64'(out_trap), 64'd0);
        end
      end
      cyc++;
    end
    if (cyc >= 20000) chk("R5", "stream stalled", 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    if (!halt_end) begin
      chk("R5", "bytes consumed", 64'(idx), 64'(stream.size()));
    end else begin
      in_valid = 1'b1; in_byte = 8'd1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        #1;
        chk("R8", "in_ready after trap", 64'(in_ready), 64'd0);
        chk("R8", "out_valid after trap", 64'(out_valid), 64'd0);
      end
      in_valid = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] op;
    logic [7:0] bad_ops[6] = '{8'd15, 8'd16, 8'd17, 8'd51, 8'd200, 8'd255};
    void'($urandom(32'd1234));

    // directed: every format, boundary registers, known immediate
    do_reset();
    add_insn(8'd0,  '0, '0);
    add_insn(8'd1,  32'h003B_003B, '0);
    add_insn(8'd12, 32'h3B00_013B, '0);
    add_insn(8'd13, 32'h0000_3B00, '0);
    add_insn(8'd29, 32'h0000_003B, 64'h0123_4567_89AB_CDEF);
    add_insn(8'd50, 32'h0000_0102, 64'h8000_0000_0000_00FF);
    add_insn(8'd45, '0, '0);
    for (int n = 0; n < 150; n++) begin
      do op = 8'($urandom % 51); while (!f_legal(op));
      add_insn(op, rand_regs(), {$urandom, $urandom});
    end
    run(1'b0);

    // R7: register byte 60 traps after full operands
    do_reset();
    add_insn(8'd3,  32'h0000_3B01, '0);
    add_insn(8'd18, 32'h0000_3C05, 64'h1122_3344_5566_7788);
    stream.push_back(8'd0); stream.push_back(8'd1);
    run(1'b1);

    // R6: illegal opcodes, one per reset
    foreach (bad_ops[i]) begin
      do_reset();
      add_insn(8'd28, 32'h0000_0203, '0);
      add_insn(bad_ops[i], '0, '0);
      stream.push_back(8'd0);
      run(1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule